// File: doc/BRIEF.md
# Peripheral clock enable sequencer

This block takes one peripheral from the stopped state to the running state in a fixed order. On an enable request it first decides whether the peripheral is already running, which it is only when its clock is on and its reset is released. If it is running, the request completes at once and nothing changes. If it is not, the block puts the peripheral into reset and waits a short settle time. It then turns the clock on and waits a longer stabilisation time before it releases the reset.

A disable request only stops the clock and leaves the reset line where it is. The two wait times are given in microseconds and turned into clock-cycle counts from the input clock frequency. A gate built without a reset line skips both waits, and an enable on such a gate simply turns the clock on. The polarity of the clock-control bit is chosen per instance. The outputs are meant to drive the per-peripheral reset and clock-stop bits of a system control register bank.

Top module: `periph_enable_seq`

## Requirements
- R1: After `rst_n` is released, `periph_rst_o` equals `RST_INIT` (forced to 0 when `HAS_RESET`=0), the clock is on when `CLK_INIT_ON`=1, and `busy` and `done` are 0.
- R2: `running` is 1 only when the clock is on and `periph_rst_o` is 0; a peripheral held in reset reads as not running even with its clock on.
- R3: An enable request while `running` is 1 gives a `done` pulse on the next cycle, leaves `busy` at 0 and changes neither `clk_bit_o` nor `periph_rst_o`.
- R4: An enable request while not running (with `HAS_RESET`=1) has these effects:
  - On the next cycle, `periph_rst_o` and `busy` are 1.
  - The clock turns on exactly RST_CYC cycles after that.
  - `periph_rst_o` falls exactly CLK_CYC cycles after the clock turns on. `busy` falls and `done` pulses on the same cycle.
  - RST_CYC = CLK_HZ*RST_WAIT_US/1e6 and CLK_CYC = CLK_HZ*CLK_WAIT_US/1e6, each at least 1.
- R5: With `HAS_RESET`=0, an enable request turns the clock on in the next cycle with a `done` pulse. `busy` and `periph_rst_o` stay 0.
- R6: A disable request while idle turns the clock off on the next cycle with a `done` pulse and leaves `periph_rst_o` unchanged.
- R7: `clk_bit_o` is 1 for clock-on when `CLK_ACTIVE_LOW`=0, and 0 for clock-on when `CLK_ACTIVE_LOW`=1.
- R8: Enable and disable requests that arrive while `busy` is 1 are ignored: the sequence timing and the clock state are unaffected.
- R9: When enable and disable are requested in the same idle cycle, the enable is served and the disable is dropped.
- R10: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_req | input | 1 | Enable request, sampled while idle |
| dis_req | input | 1 | Disable request, sampled while idle |
| periph_rst_o | output | 1 | Peripheral reset, 1 = held in reset |
| clk_bit_o | output | 1 | Clock-control bit in the configured polarity |
| busy | output | 1 | High during a timed enable sequence |
| done | output | 1 | One-cycle pulse when a request completes |
| running | output | 1 | Clock on and reset released |

## Verification
The hardest state to reach is a clock that is already on while the reset is still asserted. Here the block must ignore the running clock and still perform the full reset, wait, clock and wait ordering. The bench reaches this state directly from power-on by leaving the initial reset asserted with the clock on. It then counts cycles through a whole sequence while pulsing both request inputs mid-sequence to show that they are ignored. A second instance without a reset line and with the opposite clock polarity covers the short path.

// File: rtl/periph_enable_seq.sv
module periph_enable_seq #(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned RST_WAIT_US = 100,
  parameter int unsigned CLK_WAIT_US = 10_000,
  parameter bit          HAS_RESET   = 1'b1,
  parameter bit          CLK_ACTIVE_LOW = 1'b1,
  parameter bit          RST_INIT    = 1'b1,
  parameter bit          CLK_INIT_ON = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic dis_req,
  output logic periph_rst_o,
  output logic clk_bit_o,
  output logic busy,
  output logic done,
  output logic running
);
  localparam longint unsigned RST_RAW = (longint'(CLK_HZ) * RST_WAIT_US) / 1_000_000;
  localparam longint unsigned CLK_RAW = (longint'(CLK_HZ) * CLK_WAIT_US) / 1_000_000;
  localparam longint unsigned RST_CYC = (RST_RAW < 1) ? 1 : RST_RAW;
  localparam longint unsigned CLK_CYC = (CLK_RAW < 1) ? 1 : CLK_RAW;
  localparam longint unsigned MAX_CYC = (RST_CYC > CLK_CYC) ? RST_CYC : CLK_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_RST_WAIT, S_CLK_WAIT} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             rst_q, clk_on, done_q;

  assign periph_rst_o = rst_q;
  assign clk_bit_o    = clk_on ^ CLK_ACTIVE_LOW;
  assign busy         = (state != S_IDLE);
  assign done         = done_q;
  assign running      = clk_on && !rst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      rst_q  <= RST_INIT & HAS_RESET;
      clk_on <= CLK_INIT_ON;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (en_req) begin
            if (running || !HAS_RESET) begin
              clk_on <= 1'b1;
              done_q <= 1'b1;
            end else begin
              rst_q <= 1'b1;
              cnt   <= CNT_W'(RST_CYC - 1);
              state <= S_RST_WAIT;
            end
          end else if (dis_req) begin
            clk_on <= 1'b0;
            done_q <= 1'b1;
          end
        end
        S_RST_WAIT: begin
          if (cnt == '0) begin
            clk_on <= 1'b1;
            cnt    <= CNT_W'(CLK_CYC - 1);
            state  <= S_CLK_WAIT;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_CLK_WAIT: begin
          if (cnt == '0) begin
            rst_q  <= 1'b0;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/periph_enable_seq_chk.sv
module periph_enable_seq_chk #(
  parameter bit HAS_RESET = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic en_req,
  input logic dis_req,
  input logic periph_rst_o,
  input logic clk_bit_o,
  input logic busy,
  input logic done,
  input logic running
);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_rst_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> periph_rst_o);

  a_r4_release_ends_seq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(periph_rst_o) |-> ($fell(busy) && done));

  a_r6_disable_keeps_rst: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && dis_req && !en_req) |=> ($stable(periph_rst_o) && done));

  a_r3_noop_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && en_req && running) |=> ($stable(clk_bit_o) && $stable(periph_rst_o) && !busy && done));

  a_r8_busy_holds_clk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !running) |-> !done);

  generate
    if (!HAS_RESET) begin : g_nr
      a_r5_no_reset_path: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !periph_rst_o));
    end
  endgenerate
endmodule

bind periph_enable_seq periph_enable_seq_chk #(.HAS_RESET(HAS_RESET)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
  .periph_rst_o(periph_rst_o), .clk_bit_o(clk_bit_o), .busy(busy),
  .done(done), .running(running)
);

// File: tb/periph_enable_seq_bench.sv
module periph_enable_seq_bench;
  localparam int RST_CYC = 10;
  localparam int CLK_CYC = 1000;

  logic clk = 0, rst_n = 0;
  logic en_a = 0, dis_a = 0, en_b = 0, dis_b = 0;
  logic prst_a, cbit_a, busy_a, done_a, run_a;
  logic prst_b, cbit_b, busy_b, done_b, run_b;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  periph_enable_seq #(.CLK_HZ(100_000), .HAS_RESET(1), .CLK_ACTIVE_LOW(1),
                      .RST_INIT(1), .CLK_INIT_ON(1)) u_periph_enable_seq (
    .clk(clk), .rst_n(rst_n), .en_req(en_a), .dis_req(dis_a),
    .periph_rst_o(prst_a), .clk_bit_o(cbit_a), .busy(busy_a), .done(done_a), .running(run_a));

  periph_enable_seq #(.CLK_HZ(100_000), .HAS_RESET(0), .CLK_ACTIVE_LOW(0),
                      .RST_INIT(1), .CLK_INIT_ON(0)) u_periph_enable_seq_nr (
    .clk(clk), .rst_n(rst_n), .en_req(en_b), .dis_req(dis_b),
    .periph_rst_o(prst_b), .clk_bit_o(cbit_b), .busy(busy_b), .done(done_b), .running(run_b));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    eq("R1", "rst after reset", prst_a, 1);
    eq("R1", "clk bit (on, active-low)", cbit_a, 0);
    eq("R1", "busy after reset", busy_a, 0);
    eq("R1", "done after reset", done_a, 0);
    eq("R2", "running while held in reset", run_a, 0);
    eq("R1", "nr rst forced low", prst_b, 0);
    eq("R7", "nr clk bit off (active-high)", cbit_b, 0);
  endtask

  task automatic t_held_in_reset_enable;
    en_a = 1; step(); en_a = 0;
    eq("R2", "sequence starts though clock on", busy_a, 1);
    eq("R4", "reset asserted", prst_a, 1);
    step(3);
    en_a = 1; dis_a = 1; step(); en_a = 0; dis_a = 0;
    eq("R8", "clock still on after ignored disable", cbit_a, 0);
    step(RST_CYC + CLK_CYC - 5);
    eq("R8", "reset still held one cycle before end", prst_a, 1);
    step();
    eq("R8", "reset released on schedule", prst_a, 0);
    eq("R4", "done at end", done_a, 1);
    eq("R4", "busy low at end", busy_a, 0);
    eq("R2", "running after sequence", run_a, 1);
    step();
    eq("R10", "done single cycle", done_a, 0);
  endtask

  task automatic t_already_on;
    en_a = 1; step(); en_a = 0;
    eq("R3", "done immediately", done_a, 1);
    eq("R3", "busy stays low", busy_a, 0);
    eq("R3", "clock unchanged", cbit_a, 0);
    eq("R3", "reset unchanged", prst_a, 0);
    step();
    eq("R10", "done drops", done_a, 0);
  endtask

  task automatic t_both_req;
    en_a = 1; dis_a = 1; step(); en_a = 0; dis_a = 0;
    eq("R9", "enable wins, clock stays on", cbit_a, 0);
    eq("R9", "done for enable", done_a, 1);
    step();
  endtask

  task automatic t_disable;
    dis_a = 1; step(); dis_a = 0;
    eq("R6", "clock off", cbit_a, 1);
    eq("R6", "reset untouched", prst_a, 0);
    eq("R6", "done on disable", done_a, 1);
    eq("R2", "not running", run_a, 0);
    step();
  endtask

  task automatic t_enable_from_off;
    en_a = 1; step(); en_a = 0;
    eq("R4", "reset asserted next cycle", prst_a, 1);
    eq("R4", "busy high", busy_a, 1);
    eq("R4", "clock still off", cbit_a, 1);
    step(RST_CYC - 1);
    eq("R4", "clock off one cycle before reset wait ends", cbit_a, 1);
    step();
    eq("R4", "clock on after reset wait", cbit_a, 0);
    eq("R2", "not running while reset held", run_a, 0);
    step(CLK_CYC - 1);
    eq("R4", "reset held one cycle before clock wait ends", prst_a, 1);
    eq("R4", "no early done", done_a, 0);
    step();
    eq("R4", "reset released", prst_a, 0);
    eq("R4", "done pulse", done_a, 1);
    eq("R4", "busy low", busy_a, 0);
    step();
  endtask

  task automatic t_no_reset;
    en_b = 1; step(); en_b = 0;
    eq("R5", "clock on next cycle", cbit_b, 1);
    eq("R7", "active-high bit for on", cbit_b, 1);
    eq("R5", "done", done_b, 1);
    eq("R5", "no busy", busy_b, 0);
    eq("R5", "no reset", prst_b, 0);
    eq("R5", "running", run_b, 1);
    step();
    dis_b = 1; step(); dis_b = 0;
    eq("R6", "nr clock off", cbit_b, 0);
    eq("R6", "nr done", done_b, 1);
    step();
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step();
    t_reset_state();
    t_held_in_reset_enable();
    t_already_on();
    t_both_req();
    t_disable();
    t_enable_from_off();
    t_no_reset();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule